// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Block Transfers

This block is a slave on a two-wire serial bus. It gives a bus master access to a small bank of 8-bit control registers. The block runs on a fast system clock and oversamples the SCL and SDA lines. It answers the bus through an open-drain enable: when that enable is high, SDA is pulled low. All registers are presented in parallel, and nine output-enable lines are decoded from two of them.

Four operations are supported: byte write, byte read, block write and block read. The command byte that follows the address selects the kind of transfer and the first register. Bit 7 set means block and bit 7 clear means byte. Bits 6:0 give the starting register index. A block write carries a byte-count byte ahead of its data. A block read returns the contents of the count register ahead of its data. Block transfers step through the registers in ascending order, and every byte is shifted MSB first.

Top module: `twi_regbank`

## Requirements
- R1: After reset, registers 0 to 5 hold 0x00, 0x17, 0xF8, 0x08, 0x06 and 0xD8, and `sda_oe` is low.
- R2: The slave responds only to the 7-bit address 0x6B (0xD6 with the write bit, 0xD7 with the read bit) and acknowledges it by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and no register changes until the next start.
- R3: Byte write. A command with bit 7 = 0 is followed by one data byte, which is stored in register cmd[6:0]. Further data bytes in the same transfer are acknowledged and discarded.
- R4: Byte read. The master sends the write address, the command (bit 7 = 0) and a repeated start, then the read address. The slave then returns register cmd[6:0], MSB first. If the master acknowledges, the following registers come next in ascending order.
- R5: Block write. A command with bit 7 = 1 is followed by a count byte. Up to that many data bytes are then stored in ascending registers, starting at cmd[6:0]. Bytes beyond the count are acknowledged and discarded.
- R6: Block read. The command has bit 7 = 1. The first returned byte is the content of register 4, followed by the registers from cmd[6:0] upward. After the master NACKs a byte, the slave leaves SDA released.
- R7: An index of 6 or more is acknowledged on write and the data is discarded. A read of such an index returns 0x00.
- R8: A start or stop condition in the middle of a byte aborts the transfer and returns the slave to idle. Bytes already completed stay written, and the partial byte is dropped. The next transfer works normally.
- R9: `out_en[0]`, `[1]`, `[2]` and `[3]` follow register 1 bits 4, 2, 1 and 0. `out_en[4]` through `out_en[8]` follow register 2 bits 7 down to 3.
- R10: The slave changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| reg_q | output | 48 | All registers, register n in bits [8n+7:8n] |
| out_en | output | 9 | Output-enable lines decoded from registers 1 and 2 |

## Verification
The bench targets the count register's double role. A design that returned register data first in a block read, or advanced the index while sending the count, would shift every returned byte by one place. Surplus bytes in byte and block writes are checked, because a slave that ignored the count would overwrite the register just past the window. Aborts are issued with a stop and with a repeated start inside a data byte: a design that committed partial shifts would corrupt a register, and one that failed to reset its framing would misread the next address. Out-of-range indexes and a foreign address confirm that nothing is written and that no acknowledge is driven where none is due.

// File: rtl/twi_pkg.sv
package twi_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_RACK,
      PH_TX,
      PH_MACK
   } phase_t;

   typedef enum logic [1:0] {
      RL_ADDR,
      RL_CMD,
      RL_CNT,
      RL_DATA
   } role_t;

   localparam int NOUT = 9;

   // power-up contents of each register
   function automatic logic [7:0] reg_default(input int idx);
      logic [7:0] v;
      case (idx)
         1:       v = 8'h17;
         2:       v = 8'hF8;
         3:       v = 8'h08;
         4:       v = 8'h06;
         5:       v = 8'hD8;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

   // flat bit position in the register vector that drives enable line k
   function automatic int en_bit_pos(input int k);
      int p;
      case (k)
         0:       p = 8 + 4;
         1:       p = 8 + 2;
         2:       p = 8 + 1;
         3:       p = 8 + 0;
         default: p = 16 + 7 - (k - 4);
      endcase
      return p;
   endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES        = 2,
   parameter bit GLITCH_FILTER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_ch;
   logic [STAGES-1:0] sda_ch;
   logic              scl_q;
   logic              sda_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ch <= '1;
         sda_ch <= '1;
      end else begin
         scl_ch <= {scl_ch[STAGES-2:0], scl_i};
         sda_ch <= {sda_ch[STAGES-2:0], sda_i};
      end
   end

   generate
      if (GLITCH_FILTER) begin : g_filt
         logic scl_f;
         logic sda_f;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_f <= 1'b1;
               sda_f <= 1'b1;
            end else begin
               if (scl_ch[STAGES-1] == scl_ch[STAGES-2]) scl_f <= scl_ch[STAGES-1];
               if (sda_ch[STAGES-1] == sda_ch[STAGES-2]) sda_f <= sda_ch[STAGES-1];
            end
         end
         assign scl_s = scl_f;
         assign sda_s = sda_f;
      end else begin : g_raw
         assign scl_s = scl_ch[STAGES-1];
         assign sda_s = sda_ch[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
   parameter int NREG = 6,
   parameter int IW   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IW-1:0]      waddr,
   input  logic [7:0]         wdata,
   input  logic [IW-1:0]      raddr,
   output logic [7:0]         rdata,
   output logic [NREG*8-1:0]  reg_q
);

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= twi_pkg::reg_default(g);
            else if (we && waddr == IW'(g))      q <= wdata;
         end
         assign reg_q[g*8 +: 8] = q;
      end
   endgenerate

   // indexes past the bank read as zero
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         if (raddr == IW'(i)) rdata = reg_q[i*8 +: 8];
      end
   end

endmodule

// File: rtl/twi_proto.sv
module twi_proto
   import twi_pkg::*;
#(
   parameter logic [6:0] ADDR7   = 7'h6B,
   parameter int         IW      = 7,
   parameter int         CNT_REG = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          sda_s,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic [7:0]    rdata,
   output logic          sda_oe,
   output logic          we,
   output logic [IW-1:0] waddr,
   output logic [7:0]    wdata,
   output logic [IW-1:0] raddr,
   output logic          idle
);

   phase_t        ph;
   role_t         role;
   logic [7:0]    sh;
   logic [3:0]    nbit;
   logic          rd_mode;
   logic          blk;
   logic          first_pending;
   logic          mnack;
   logic [IW-1:0] ptr;
   logic [7:0]    remain;

   // the count register stands in for the index on the first byte of a block read
   assign raddr = (first_pending && blk) ? IW'(CNT_REG) : ptr;
   assign idle  = (ph == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph            <= PH_IDLE;
         role          <= RL_ADDR;
         sh            <= '0;
         nbit          <= '0;
         rd_mode       <= 1'b0;
         blk           <= 1'b0;
         first_pending <= 1'b0;
         mnack         <= 1'b0;
         ptr           <= '0;
         remain        <= '0;
         sda_oe        <= 1'b0;
         we            <= 1'b0;
         waddr         <= '0;
         wdata         <= '0;
      end else begin
         we <= 1'b0;
         if (start_det) begin
            ph     <= PH_RX;
            role   <= RL_ADDR;
            nbit   <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            ph     <= PH_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (ph)
               PH_RX: begin
                  if (scl_rise && nbit != 4'd8) begin
                     sh   <= {sh[6:0], sda_s};
                     nbit <= nbit + 4'd1;
                  end else if (scl_fall && nbit == 4'd8) begin
                     nbit   <= '0;
                     ph     <= PH_RACK;
                     sda_oe <= 1'b1;
                     case (role)
                        RL_ADDR: begin
                           if (sh[7:1] == ADDR7) begin
                              rd_mode       <= sh[0];
                              first_pending <= sh[0];
                           end else begin
                              ph     <= PH_IDLE;
                              sda_oe <= 1'b0;
                           end
                        end
                        RL_CMD: begin
                           blk    <= sh[7];
                           ptr    <= sh[IW-1:0];
                           remain <= sh[7] ? 8'd0 : 8'd1;
                        end
                        RL_CNT: remain <= sh;
                        default: begin
                           if (remain != 8'd0) begin
                              we     <= 1'b1;
                              waddr  <= ptr;
                              wdata  <= sh;
                              ptr    <= ptr + 1'b1;
                              remain <= remain - 8'd1;
                           end
                        end
                     endcase
                  end
               end
               PH_RACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     if (role == RL_ADDR && rd_mode) begin
                        sda_oe        <= ~rdata[7];
                        sh            <= {rdata[6:0], 1'b0};
                        nbit          <= 4'd1;
                        ph            <= PH_TX;
                        first_pending <= 1'b0;
                        if (!(first_pending && blk)) ptr <= ptr + 1'b1;
                     end else begin
                        ph <= PH_RX;
                        case (role)
                           RL_ADDR: role <= RL_CMD;
                           RL_CMD:  role <= blk ? RL_CNT : RL_DATA;
                           default: role <= RL_DATA;
                        endcase
                     end
                  end
               end
               PH_TX: begin
                  if (scl_fall) begin
                     if (nbit == 4'd8) begin
                        sda_oe <= 1'b0;
                        ph     <= PH_MACK;
                     end else begin
                        sda_oe <= ~sh[7];
                        sh     <= {sh[6:0], 1'b0};
                        nbit   <= nbit + 4'd1;
                     end
                  end
               end
               PH_MACK: begin
                  if (scl_rise) begin
                     mnack <= sda_s;
                  end else if (scl_fall) begin
                     if (mnack) begin
                        ph <= PH_IDLE;
                     end else begin
                        sda_oe <= ~rdata[7];
                        sh     <= {rdata[6:0], 1'b0};
                        nbit   <= 4'd1;
                        ph     <= PH_TX;
                        ptr    <= ptr + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/twi_regbank.sv
module twi_regbank #(
   parameter logic [6:0] ADDR7         = 7'h6B,
   parameter int         NREG          = 6,
   parameter int         CNT_REG       = 4,
   parameter int         SYNC_STAGES   = 2,
   parameter bit         GLITCH_FILTER = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   output logic [NREG*8-1:0]     reg_q,
   output logic [twi_pkg::NOUT-1:0] out_en
);

   localparam int IW = 7;

   logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic          wr_en, proto_idle;
   logic [IW-1:0] wr_addr, rd_addr;
   logic [7:0]    wr_data, rd_data;

   generate
      if (NREG <= CNT_REG || NREG < 3 || NREG > (1 << IW)) begin : g_bad_nreg
         $error("twi_regbank: NREG must hold the count and enable registers");
      end
   endgenerate

   twi_line_sync #(
      .STAGES        (SYNC_STAGES),
      .GLITCH_FILTER (GLITCH_FILTER)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   twi_proto #(
      .ADDR7   (ADDR7),
      .IW      (IW),
      .CNT_REG (CNT_REG)
   ) u_proto (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_s     (sda_s),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rdata     (rd_data),
      .sda_oe    (sda_oe),
      .we        (wr_en),
      .waddr     (wr_addr),
      .wdata     (wr_data),
      .raddr     (rd_addr),
      .idle      (proto_idle)
   );

   twi_regfile #(
      .NREG (NREG),
      .IW   (IW)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_data),
      .reg_q (reg_q)
   );

   generate
      for (genvar k = 0; k < twi_pkg::NOUT; k++) begin : g_en
         assign out_en[k] = reg_q[twi_pkg::en_bit_pos(k)];
      end
   endgenerate

endmodule

// File: rtl/twi_regbank_chk.sv
module twi_regbank_chk #(
   parameter int NREG = 6,
   parameter int IW   = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     scl_s,
   input logic                     stop_det,
   input logic                     idle,
   input logic                     we,
   input logic [IW-1:0]            waddr,
   input logic [7:0]               wdata,
   input logic [NREG*8-1:0]        reg_q,
   input logic [twi_pkg::NOUT-1:0] out_en,
   input logic                     sda_oe
);

   // R10: drive changes only with the clock line low
   a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R8: a stop always lands the slave in idle
   a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> idle);

   // R2: no drive while idle
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !sda_oe);

   // R3: an in-range write appears in the register vector one cycle later
   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr < NREG) |=> 8'(reg_q >> {$past(waddr), 3'b000}) == $past(wdata));

   // R7: out-of-range writes leave every register alone
   a_r7_oor_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr >= NREG) |=> $stable(reg_q));

   // R9: enables move only when registers move
   a_r9_en_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_en) |-> !$stable(reg_q));

endmodule

bind twi_regbank twi_regbank_chk #(.NREG(NREG), .IW(IW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .stop_det (stop_det),
   .idle     (proto_idle),
   .we       (wr_en),
   .waddr    (wr_addr),
   .wdata    (wr_data),
   .reg_q    (reg_q),
   .out_en   (out_en),
   .sda_oe   (sda_oe)
);

// File: tb/twi_regbank_tb.sv
`timescale 1ns/1ps
module twi_regbank_tb;

   localparam int QTR  = 10;
   localparam int NVEC = 9;
   localparam logic [1:0] OP_BW = 2'd0, OP_BR = 2'd1, OP_KW = 2'd2, OP_KR = 2'd3;

   // {count of data bytes, op, index, byte count, data bytes}
   localparam logic [53:0] VEC [NVEC] = '{
      {4'd1, OP_BW, 8'h01, 8'h00, 32'h05000000},
      {4'd1, OP_BR, 8'h01, 8'h00, 32'h00000000},
      {4'd3, OP_KW, 8'h02, 8'h03, 32'hA1B2C300},
      {4'd4, OP_KR, 8'h02, 8'h00, 32'h00000000},
      {4'd1, OP_BW, 8'h04, 8'h00, 32'h02000000},
      {4'd3, OP_KR, 8'h00, 8'h00, 32'h00000000},
      {4'd3, OP_KW, 8'h03, 8'h02, 32'h11223300},
      {4'd2, OP_BW, 8'h00, 8'h00, 32'h44550000},
      {4'd2, OP_BR, 8'h05, 8'h00, 32'h00000000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_oe;
   logic [47:0] reg_q;
   logic [8:0]  out_en;
   wire         sda_bus = m_sda & ~sda_oe;

   logic [7:0]  mdl [0:5];
   int          checks = 0;
   int          fails = 0;

   always #2.5 clk = ~clk;

   twi_regbank u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (m_scl),
      .sda_i  (sda_bus),
      .sda_oe (sda_oe),
      .reg_q  (reg_q),
      .out_en (out_en)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input int a);
      return (a < 6) ? mdl[a] : 8'h00;
   endfunction

   task automatic cmp_regs(input string tag);
      logic [8:0] en;
      for (int i = 0; i < 6; i++) chk(reg_q[i*8 +: 8] == mdl[i], tag, reg_q[i*8 +: 8], mdl[i]);
      en = {mdl[2][3], mdl[2][4], mdl[2][5], mdl[2][6], mdl[2][7],
            mdl[1][0], mdl[1][1], mdl[1][2], mdl[1][4]};
      chk(out_en == en, "R9", out_en, en);
   endtask

   task automatic wq();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b1; wq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; wq();
         m_scl = 1'b1; wq(); wq();
         m_scl = 1'b0; wq();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      ack = !sda_bus; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic recv_byte(input bit last, output logic [7:0] b);
      logic oe_hi;
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq();
         m_scl = 1'b1; wq();
         b[i] = sda_bus; oe_hi = sda_oe; wq();
         chk(sda_oe == oe_hi, "R10", sda_oe, oe_hi);
         m_scl = 1'b0; wq();
      end
      m_sda = last; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
      m_sda = 1'b1;
   endtask

   task automatic op_write(input logic [7:0] idx, input bit blk, input logic [7:0] cnt,
                           input logic [31:0] data, input int n, input string tag);
      bit ack;
      bus_start();
      send_byte(8'hD6, ack); chk(ack, "R2", ack, 1);
      send_byte({blk, idx[6:0]}, ack); chk(ack, tag, ack, 1);
      if (blk) begin
         send_byte(cnt, ack); chk(ack, tag, ack, 1);
      end
      for (int k = 0; k < n; k++) begin
         send_byte(data[31-8*k -: 8], ack); chk(ack, tag, ack, 1);
      end
      bus_stop(); wq();
      for (int k = 0; k < n; k++) begin
         int a;
         a = int'(idx[6:0]) + k;
         if ((blk && k < int'(cnt)) || (!blk && k == 0)) begin
            if (a < 6) mdl[a] = data[31-8*k -: 8];
         end
      end
      cmp_regs(tag);
   endtask

   task automatic op_read(input logic [7:0] idx, input bit blk, input int n, input string tag);
      bit ack;
      logic [7:0] b, e;
      bus_start();
      send_byte(8'hD6, ack); chk(ack, "R2", ack, 1);
      send_byte({blk, idx[6:0]}, ack); chk(ack, tag, ack, 1);
      bus_rstart();
      send_byte(8'hD7, ack); chk(ack, "R2", ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k == n - 1, b);
         if (blk) e = (k == 0) ? mdl[4] : exp_rd(int'(idx[6:0]) + k - 1);
         else     e = exp_rd(int'(idx[6:0]) + k);
         chk(b == e, tag, b, e);
      end
      wq();
      chk(sda_oe == 1'b0, "R6", sda_oe, 0);
      bus_stop(); wq();
      cmp_regs(tag);
   endtask

   task automatic finish_up();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired before the run completed");
      finish_up();
   end

   initial begin
      bit ack;
      mdl[0] = 8'h00; mdl[1] = 8'h17; mdl[2] = 8'hF8;
      mdl[3] = 8'h08; mdl[4] = 8'h06; mdl[5] = 8'hD8;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wq();

      // R1 reset state, R9 all enables on
      cmp_regs("R1");
      chk(sda_oe == 1'b0, "R1", sda_oe, 0);
      chk(out_en == 9'h1FF, "R9", out_en, 9'h1FF);

      // vector walk: R3, R4, R5, R6
      for (int v = 0; v < NVEC; v++) begin
         logic [53:0] ent;
         string tag;
         ent = VEC[v];
         case (ent[49:48])
            OP_BW: tag = "R3";
            OP_BR: tag = "R4";
            OP_KW: tag = "R5";
            default: tag = "R6";
         endcase
         if (ent[49:48] == OP_BW || ent[49:48] == OP_KW)
            op_write(ent[47:40], ent[49], ent[39:32], ent[31:0], int'(ent[53:50]), tag);
         else
            op_read(ent[47:40], ent[49], int'(ent[53:50]), tag);
      end

      // R2 foreign address: no acknowledge, nothing written
      bus_start();
      send_byte(8'hA0, ack); chk(!ack, "R2", ack, 0);
      send_byte(8'h01, ack);
      send_byte(8'h00, ack);
      bus_stop(); wq();
      cmp_regs("R2");

      // R7 out-of-range indexes
      op_write(8'h06, 1'b0, 8'h00, 32'h77000000, 1, "R7");
      op_read(8'h50, 1'b0, 1, "R7");
      op_write(8'h05, 1'b1, 8'h02, 32'h3C4D0000, 2, "R7");

      // R8 stop inside a data byte after one completed byte
      bus_start();
      send_byte(8'hD6, ack);
      send_byte(8'h80, ack);
      send_byte(8'h03, ack);
      send_byte(8'h9C, ack);
      send_bits(8'hFF, 4);
      bus_stop(); wq();
      mdl[0] = 8'h9C;
      cmp_regs("R8");

      // R8 repeated start inside a data byte
      bus_start();
      send_byte(8'hD6, ack);
      send_byte(8'h02, ack);
      send_bits(8'h00, 3);
      bus_rstart();
      bus_stop(); wq();
      cmp_regs("R8");
      op_read(8'h02, 1'b0, 1, "R8");

      finish_up();
   end

endmodule